// File: doc/BRIEF.md
# Incremental PID Controller Datapath

This block is the arithmetic core of a sampled-data PID loop written in velocity form. Each accepted sample strobe brings in one signed 16-bit error word. The block forms a new control word from four terms: the control word it produced last time, and the current error and the two errors before it, each of those three multiplied by its own gain. It keeps the two previous errors and the previous output internally. The three gains are plain inputs, so software can change them between samples while the structure stays fixed.

The three products and the aligned previous output are combined by a carry-save reduction into a sum word and a carry word. A single carry-propagate addition then resolves them. The result is rounded back to the output width and clamped. The clamped value is what the controller remembers, so the integrating action cannot run away beyond the output range. A new output and a one-cycle valid pulse appear two cycles after the strobe. A strobe that arrives while the previous sample is still in the pipeline is dropped, and a sticky flag records the loss.

Top module: `pid_incr_top`

## Requirements
- R1: While reset is asserted, and after it is released, ctl_out is 0, ctl_valid is 0 and overrun is 0. The stored error history and stored output are zero, so the first result after reset equals round(K1·e[k]).
- R2: An accepted sample gives S = u[k-1]·4096 + K1·e[k] + K2·e[k-1] + K3·e[k-2]. The gains are signed Q4.12, so 16'h1000 means 1.0 and 16'hF000 means -1.0. The output is S scaled back by 4096.
- R3: The scale-back rounds half up: u = floor((S + 2048) / 4096). For example, S = 2048 gives 1, S = -2048 gives 0, and S = 6144 gives 2.
- R4: A rounded value above 32767 is output as 32767, and a rounded value below -32768 is output as -32768. The output never wraps.
- R5: The saturated output is the u[k-1] used by the next sample. After a clamp at 32767, a sample with K1 = 1.0 and e = -1 gives 32766.
- R6: On each accepted strobe, e[k-1] moves to e[k-2] and err_in becomes e[k-1]. A strobe that is not accepted leaves the history unchanged.
- R7: A strobe accepted at clock edge n updates ctl_out at edge n+1. ctl_valid is high for exactly the one cycle after edge n+1. ctl_out does not change at any other time.
- R8: A strobe that is high at the edge just after an accepted strobe is ignored. It changes neither the history nor the outputs, and it sets overrun from the following cycle on. Only reset clears overrun.
- R9: Gains are used only at the edge where a strobe is accepted. Gain values presented in other cycles have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sample_stb | input | 1 | Sample strobe; high for one cycle to present err_in |
| err_in | input | 16 | Signed error sample |
| gain_k1 | input | 16 | Signed Q4.12 gain on the current error |
| gain_k2 | input | 16 | Signed Q4.12 gain on the previous error |
| gain_k3 | input | 16 | Signed Q4.12 gain on the error two samples back |
| ctl_out | output | 16 | Signed saturated control word |
| ctl_valid | output | 1 | One-cycle pulse marking a new ctl_out |
| overrun | output | 1 | Sticky flag: a strobe was dropped while busy |

## Verification
A corrupted history register or stored output does not show up straight away. The faulty value reaches the port in the next one or two results, because each output depends on up to two prior errors and on every earlier clamped output. The bench therefore runs chains of several samples per gain set and compares every result against a model of the difference equation. It also brackets rounding ties and both clamp edges. A dropped or extra pulse, or a pulse one cycle early or late, shows up at the port as a result that is missing, unexpected or arrives in the wrong cycle. An ignored strobe that leaks into the history shows up as a wrong value in the next result.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam int unsigned PID_DATA_W = 16;
  localparam int unsigned PID_GAIN_W = 16;
  localparam int unsigned PID_FRAC_W = 12;
  localparam int unsigned PID_TAPS   = 3;
endpackage

// File: rtl/pid_rst_sync.sv
module pid_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_q  <= meta_q;
    end
  end
endmodule

// File: rtl/pid_tap_stage.sv
module pid_tap_stage #(
  parameter int unsigned DW   = pid_pkg::PID_DATA_W,
  parameter int unsigned GW   = pid_pkg::PID_GAIN_W,
  parameter int unsigned TAPS = pid_pkg::PID_TAPS,
  localparam int unsigned PW  = DW + GW
) (
  input  logic                 clk,
  input  logic                 rst_q,
  input  logic                 accept,
  input  logic signed [DW-1:0] err_in,
  input  logic signed [GW-1:0] gain [TAPS],
  output logic signed [PW-1:0] prod [TAPS]
);
  // hist[0] is the current sample; hist[i] for i>0 are registered.
  logic signed [DW-1:0] hist   [TAPS];
  logic signed [DW-1:0] hist_d [TAPS];
  logic signed [PW-1:0] prod_d [TAPS];

  assign hist[0] = err_in;

  genvar i;
  generate
    for (i = 0; i < TAPS; i++) begin : g_tap
      logic signed [PW-1:0] mult;
      assign mult = hist[i] * gain[i];

      always_comb begin
        prod_d[i] = accept ? mult : prod[i];
      end

      always_ff @(posedge clk or negedge rst_q) begin
        if (!rst_q) prod[i] <= '0;
        else        prod[i] <= prod_d[i];
      end

      if (i > 0) begin : g_hist
        always_comb begin
          hist_d[i] = accept ? hist[i-1] : hist[i];
        end

        always_ff @(posedge clk or negedge rst_q) begin
          if (!rst_q) hist[i] <= '0;
          else        hist[i] <= hist_d[i];
        end

        assert_hist_hold_R6: assert property (@(posedge clk) disable iff (!rst_q)
          !accept |=> $stable(hist[i]));
      end else begin : g_cur
        assign hist_d[i] = err_in;
      end
    end
  endgenerate
endmodule

// File: rtl/pid_csa4.sv
module pid_csa4 #(
  parameter int unsigned W = 34
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  input  logic [W-1:0] op_d,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  logic [W-1:0] s1, c1, chk_tree, chk_ref;

  // first 3:2 layer
  always_comb begin
    s1 = op_a ^ op_b ^ op_c;
    c1 = ((op_a & op_b) | (op_a & op_c) | (op_b & op_c)) << 1;
  end

  // second 3:2 layer folds in the fourth operand
  always_comb begin
    sum_o   = s1 ^ c1 ^ op_d;
    carry_o = ((s1 & c1) | (s1 & op_d) | (c1 & op_d)) << 1;
  end

  always_comb begin
    chk_tree = sum_o + carry_o;
    chk_ref  = op_a + op_b + op_c + op_d;
    if (!$isunknown({op_a, op_b, op_c, op_d})) begin
      assert_csa_total_R2: assert (chk_tree == chk_ref);
    end
  end
endmodule

// File: rtl/pid_round_sat.sv
module pid_round_sat #(
  parameter int unsigned AW   = 34,
  parameter int unsigned FRAC = pid_pkg::PID_FRAC_W,
  parameter int unsigned OW   = pid_pkg::PID_DATA_W,
  localparam int unsigned RW  = AW - FRAC
) (
  input  logic [AW-1:0]        sum_i,
  input  logic [AW-1:0]        carry_i,
  output logic signed [OW-1:0] y_o
);
  localparam logic [AW-1:0]        HALF = AW'(1) << (FRAC - 1);
  localparam logic signed [RW-1:0] MAXC = RW'((2 ** (OW - 1)) - 1);
  localparam logic signed [RW-1:0] MINC = -MAXC - RW'(1);

  logic [AW-1:0]        wide;
  logic signed [RW-1:0] rnd;

  always_comb begin
    wide = sum_i + carry_i + HALF;
    rnd  = $signed(wide[AW-1:FRAC]);
    if (rnd > MAXC)      y_o = MAXC[OW-1:0];
    else if (rnd < MINC) y_o = MINC[OW-1:0];
    else                 y_o = rnd[OW-1:0];
  end
endmodule

// File: rtl/pid_incr_top.sv
module pid_incr_top #(
  parameter int unsigned DW   = pid_pkg::PID_DATA_W,
  parameter int unsigned GW   = pid_pkg::PID_GAIN_W,
  parameter int unsigned FRAC = pid_pkg::PID_FRAC_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_stb,
  input  logic signed [DW-1:0] err_in,
  input  logic signed [GW-1:0] gain_k1,
  input  logic signed [GW-1:0] gain_k2,
  input  logic signed [GW-1:0] gain_k3,
  output logic signed [DW-1:0] ctl_out,
  output logic                 ctl_valid,
  output logic                 overrun
);
  localparam int unsigned TAPS = pid_pkg::PID_TAPS;
  localparam int unsigned PW   = DW + GW;
  localparam int unsigned AW   = PW + 2;
  localparam int unsigned PEXT = AW - PW;
  localparam int unsigned UEXT = AW - DW - FRAC;

  logic rst_q;
  logic s1_valid, s1_valid_d;
  logic accept;
  logic ovr_d, valid_d;
  logic signed [DW-1:0] ctl_d, y_sat;
  logic signed [GW-1:0] gain [TAPS];
  logic signed [PW-1:0] prod [TAPS];
  logic [AW-1:0] op_u, op_p0, op_p1, op_p2, csa_s, csa_c;

  pid_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  assign gain[0] = gain_k1;
  assign gain[1] = gain_k2;
  assign gain[2] = gain_k3;

  assign accept = rst_q & sample_stb & ~s1_valid;

  pid_tap_stage #(.DW(DW), .GW(GW), .TAPS(TAPS)) u_taps (
    .clk(clk), .rst_q(rst_q), .accept(accept),
    .err_in(err_in), .gain(gain), .prod(prod)
  );

  always_comb begin
    op_u  = {{UEXT{ctl_out[DW-1]}}, ctl_out, {FRAC{1'b0}}};
    op_p0 = {{PEXT{prod[0][PW-1]}}, prod[0]};
    op_p1 = {{PEXT{prod[1][PW-1]}}, prod[1]};
    op_p2 = {{PEXT{prod[2][PW-1]}}, prod[2]};
  end

  pid_csa4 #(.W(AW)) u_csa (
    .op_a(op_u), .op_b(op_p0), .op_c(op_p1), .op_d(op_p2),
    .sum_o(csa_s), .carry_o(csa_c)
  );

  pid_round_sat #(.AW(AW), .FRAC(FRAC), .OW(DW)) u_rs (
    .sum_i(csa_s), .carry_i(csa_c), .y_o(y_sat)
  );

  // next state
  always_comb begin
    s1_valid_d = accept;
    valid_d    = s1_valid;
    ctl_d      = s1_valid ? y_sat : ctl_out;
    ovr_d      = overrun | (sample_stb & s1_valid);
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      s1_valid  <= 1'b0;
      ctl_valid <= 1'b0;
      ctl_out   <= '0;
      overrun   <= 1'b0;
    end else begin
      s1_valid  <= s1_valid_d;
      ctl_valid <= valid_d;
      ctl_out   <= ctl_d;
      overrun   <= ovr_d;
    end
  end

  assert_valid_after_two_R7: assert property (@(posedge clk) disable iff (!rst_q)
    ctl_valid |-> $past(accept, 2));
  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_q)
    ctl_valid |=> !ctl_valid);
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_q)
    !ctl_valid |-> $stable(ctl_out));
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_q)
    overrun |=> overrun);
  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(overrun) |-> $past(sample_stb && !accept));
endmodule

// File: tb/sim_pid_incr_top.sv
module sim_pid_incr_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_stb = 1'b0;
  logic signed [15:0] err_in = '0, gain_k1 = '0, gain_k2 = '0, gain_k3 = '0;
  logic signed [15:0] ctl_out;
  logic ctl_valid, overrun;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  int q_val[$];
  int q_cyc[$];
  string q_tag[$];
  int u_m = 0, e1_m = 0, e2_m = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pid_incr_top u0 (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .err_in(err_in),
    .gain_k1(gain_k1), .gain_k2(gain_k2), .gain_k3(gain_k3),
    .ctl_out(ctl_out), .ctl_valid(ctl_valid), .overrun(overrun)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model(int k1, int k2, int k3, int e0);
    longint s, r;
    s = (longint'(u_m) * 4096) + longint'(k1) * e0 + longint'(k2) * e1_m
        + longint'(k3) * e2_m;
    r = (s + 2048) >>> 12;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  // Driver: one accepted strobe, then one idle cycle with junk gains (R9).
  // If hold is set, the strobe stays high one extra cycle and must be dropped (R8).
  task automatic send(input int e, input int k1, input int k2, input int k3,
                      input string tag, input bit hold = 0);
    int v;
    @(negedge clk);
    err_in = 16'(e); gain_k1 = 16'(k1); gain_k2 = 16'(k2); gain_k3 = 16'(k3);
    sample_stb = 1'b1;
    @(posedge clk);
    #1;
    v = model(k1, k2, k3, e);
    q_val.push_back(v); q_cyc.push_back(cyc); q_tag.push_back(tag);
    u_m = v; e2_m = e1_m; e1_m = e;
    @(negedge clk);
    gain_k1 = 16'sh5A5A; gain_k2 = 16'sh7123; gain_k3 = -16'sh2222;
    if (hold) err_in = 16'sh4321;
    else sample_stb = 1'b0;
    if (hold) begin
      @(negedge clk);
      sample_stb = 1'b0;
    end
  endtask

  // Monitor: pops expected results as ctl_valid pulses
  always @(negedge clk) begin
    if (rst_n && ctl_valid) begin
      if (q_val.size() == 0) begin
        check("R7 unexpected valid", 1, 0);
      end else begin
        check({q_tag[0], " value"}, int'(ctl_out), q_val[0]);
        check("R7 timing", cyc, q_cyc[0] + 1);
        void'(q_val.pop_front()); void'(q_cyc.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sample_stb = 1'b0;
    #1;
    check("R1 out in reset", int'(ctl_out), 0);
    check("R1 valid in reset", int'(ctl_valid), 0);
    check("R1 overrun in reset", int'(overrun), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    u_m = 0; e1_m = 0; e2_m = 0;
    repeat (4) @(negedge clk);
    check("R1 out after reset", int'(ctl_out), 0);
    check("R1 overrun after reset", int'(overrun), 0);
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
    check("R7 all results seen", q_val.size(), 0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5 * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    do_reset();
    // R1/R2: pure integrator, first result is round(K1*e)
    send(100, 16'h1000, 0, 0, "R1 first");
    send(-30, 16'h1000, 0, 0, "R2 integrate");
    send(7, 16'h1000, 0, 0, "R2 integrate");
    // R2/R6: all three taps, mixed signs
    send(10, 16'h2000, -4096, 16'h0800, "R6 taps");
    send(20, 16'h2000, -4096, 16'h0800, "R6 taps");
    send(-5, 16'h2000, -4096, 16'h0800, "R6 taps");
    send(-300, 16'h1800, 16'h0400, -2048, "R2 mix");
    drain();
    // R3: half-up rounding ties from a clean state
    do_reset();
    send(1, 16'h0800, 0, 0, "R3 tie +");
    send(-1, 16'h0800, 0, 0, "R3 tie -");
    send(3, 16'h0800, 0, 0, "R3 tie 3");
    send(-3, 16'h0800, 0, 0, "R3 tie -3");
    send(1, 16'h0001, 16'h0001, 16'h0001, "R3 tiny");
    drain();
    // R4/R5: positive clamp then recovery from the clamp
    send(32767, 16'h7FFF, 0, 0, "R4 clamp +");
    send(32767, 16'h7FFF, 0, 0, "R4 clamp +");
    send(-1, 16'h1000, 0, 0, "R5 unwind");
    // negative clamp
    send(-32768, 16'h7FFF, 0, 0, "R4 clamp -");
    send(-32768, -32768, -32768, 0, "R4 clamp -");
    send(1, 16'h1000, 0, 0, "R5 unwind -");
    drain();
    // R8: dropped strobe; history must not see 0x4321
    check("R8 overrun clear", int'(overrun), 0);
    send(50, 16'h1000, 16'h1000, 16'h1000, "R8 before drop", 1);
    @(negedge clk);
    check("R8 overrun set", int'(overrun), 1);
    send(60, 16'h1000, 16'h1000, 16'h1000, "R8 history after drop");
    send(70, 16'h1000, 16'h1000, 16'h1000, "R6 history after drop");
    drain();
    check("R8 overrun sticky", int'(overrun), 1);
    // R9: fastest rate, junk gains between strobes
    send(1000, 16'h0C00, -1024, 16'h0200, "R9 gains");
    send(-2000, 16'h0C00, -1024, 16'h0200, "R9 gains");
    send(1500, 16'h0C00, -1024, 16'h0200, "R9 gains");
    drain();
    do_reset();
    send(-12345, 16'h1000, 16'h7000, 16'h7000, "R1 after second reset");
    drain();
    finish_up();
  end
endmodule